// File: doc/BRIEF.md
# Iterative Integer Divider with Non-Trapping Corner Cases

This block computes the quotient of two 32-bit integers, one bit per clock. A single select input picks the operand interpretation. In unsigned mode both operands are plain binary. In signed mode both are two's complement. A signed quotient is rounded toward zero.

The block never raises an error. A divisor of zero is replaced by one. The signed overflow case, the most negative value divided by minus one, also has its divisor replaced by one. In both cases the dividend comes back unchanged as the quotient.

A caller pulses `start_i` with the operands while `busy_o` is low. The block then stays busy for W cycles. It presents the quotient together with a one-cycle `done_o`. The quotient output holds that value until the next completion.

Top module: `iter_div`

## Requirements
- R1: With `signed_i`=1, operands are W-bit two's complement and the quotient is the exact quotient truncated toward zero; its sign is negative exactly when the operand signs differ and the magnitude is nonzero.
- R2: With `signed_i`=0, operands are W-bit unsigned and the quotient is floor(dividend / divisor).
- R3: A divisor of zero yields a quotient equal to the dividend in both modes.
- R4: In signed mode, a dividend of only the MSB set (0x80000000) with a divisor of all ones yields 0x80000000.
- R5: A start accepted at a rising edge raises `busy_o`, which stays high for exactly W cycles; `done_o` rises at the edge where `busy_o` falls.
- R6: `done_o` is high for exactly one cycle per accepted start and is never high together with `busy_o`.
- R7: `start_i` while `busy_o` is high is ignored: its operands do not affect the quotient in progress.
- R8: `quotient_o` changes only at the edge that raises `done_o` and otherwise holds its value.
- R9: After reset `busy_o`=0, `done_o`=0 and `quotient_o`=0.
- R10: A start presented in the cycle `done_o` is high is accepted, so divisions can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division when not busy |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_i | input | W | Dividend, sampled on accepted start |
| divisor_i | input | W | Divisor, sampled on accepted start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion strobe |
| quotient_o | output | W | Last completed quotient |

## Verification
A completion strobe and the acceptance of the next start can fall in the same cycle. The bench provokes this by watching for `done_o` and presenting fresh operands in that same cycle. The reference model must then show `busy_o` high on the very next cycle. It must also show the first quotient held until the second result lands exactly W cycles later. Separately, a start pulse with different operands is driven in the middle of a division. That division's result must still match the original operands.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
  typedef enum logic {
    MODE_UNS = 1'b0,
    MODE_SGN = 1'b1
  } div_mode_e;
endpackage

// File: rtl/div_negate.sv
`timescale 1ns/1ps
module div_negate #(
  parameter int W = 32
) (
  input  logic         neg_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  always_comb val_o = neg_i ? (~val_i + W'(1)) : val_i;
endmodule

// File: rtl/div_prep.sv
`timescale 1ns/1ps
module div_prep
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  div_mode_e    mode_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_o
);
  localparam logic [W-1:0] MinNeg = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] AllOne = {W{1'b1}};

  logic         sgn;
  logic         a_neg, b_neg_raw, b_neg;
  logic         subst;
  logic [W-1:0] b_eff;
  logic [W-1:0] b_mag;

  always_comb begin
    sgn       = (mode_i == MODE_SGN);
    a_neg     = sgn & dividend_i[W-1];
    b_neg_raw = sgn & divisor_i[W-1];
    // zero divisor, or signed overflow: force divisor to one
    subst     = (divisor_i == '0) ||
                (sgn && dividend_i == MinNeg && divisor_i == AllOne);
    b_eff     = subst ? W'(1) : divisor_i;
    b_neg     = subst ? 1'b0 : b_neg_raw;
    neg_o     = a_neg ^ b_neg;
    mag_b_o   = subst ? W'(1) : b_mag;
  end

  div_negate #(.W(W)) u_abs_a (.neg_i(a_neg), .val_i(dividend_i), .val_o(mag_a_o));
  div_negate #(.W(W)) u_abs_b (.neg_i(b_neg), .val_i(b_eff),      .val_o(b_mag));
endmodule

// File: rtl/div_core.sv
`timescale 1ns/1ps
module div_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic         busy_o,
  output logic         last_o,
  output logic [W-1:0] quo_next_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [W:0]    shifted, diff;
  logic [W-1:0]  rem_next;
  logic          fits;

  always_comb begin
    shifted    = {rem_q, quo_q[W-1]};
    diff       = shifted - {1'b0, dvs_q};
    fits       = ~diff[W];
    rem_next   = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_next_o = {quo_q[W-2:0], fits};
    busy_o     = (cnt_q != '0);
    last_o     = (cnt_q == CW'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CW'(1);
      rem_q <= rem_next;
      quo_q <= quo_next_o;
    end else if (load_i) begin
      cnt_q <= CW'(W);
      rem_q <= '0;
      quo_q <= mag_a_i;
      dvs_q <= mag_b_i;
    end
  end
endmodule

// File: rtl/iter_div.sv
`timescale 1ns/1ps
module iter_div
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o
);
  logic         core_busy, core_last, load;
  logic [W-1:0] mag_a, mag_b, quo_next, quo_fixed;
  logic         neg, neg_q, done_q;
  logic [W-1:0] quo_q;
  div_mode_e    mode;

  always_comb begin
    mode = signed_i ? MODE_SGN : MODE_UNS;
    load = start_i & ~core_busy;
  end

  div_prep #(.W(W)) u_prep (
    .mode_i(mode), .dividend_i(dividend_i), .divisor_i(divisor_i),
    .mag_a_o(mag_a), .mag_b_o(mag_b), .neg_o(neg)
  );

  div_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .mag_a_i(mag_a), .mag_b_i(mag_b),
    .busy_o(core_busy), .last_o(core_last), .quo_next_o(quo_next)
  );

  div_negate #(.W(W)) u_fix (.neg_i(neg_q), .val_i(quo_next), .val_o(quo_fixed));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q  <= 1'b0;
      done_q <= 1'b0;
      quo_q  <= '0;
    end else begin
      done_q <= core_last;
      if (load)      neg_q <= neg;
      if (core_last) quo_q <= quo_fixed;
    end
  end

  assign busy_o     = core_busy;
  assign done_o     = done_q;
  assign quotient_o = quo_q;
endmodule

// File: rtl/iter_div_chk.sv
`timescale 1ns/1ps
module iter_div_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quotient_o
);
  int run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  a_r6_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r5_fall_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r5_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_cnt == W);
  a_r8_quotient_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(quotient_o) |-> done_o);
endmodule

bind iter_div iter_div_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .quotient_o(quotient_o)
);

// File: tb/iter_div_tb.sv
`timescale 1ns/1ps
module iter_div_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sgn = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         busy, done;
  logic [W-1:0] q;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R9";

  int           m_cnt = 0;
  logic         exp_done = 1'b0;
  logic [W-1:0] exp_q = '0, m_res = '0;

  always #2.5 clk = ~clk;

  iter_div #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dividend_i(a), .divisor_i(b),
    .busy_o(busy), .done_o(done), .quotient_o(q)
  );

  function automatic logic [W-1:0] ref_q(bit s, logic [W-1:0] x, logic [W-1:0] y);
    longint sx, sy;
    if (s) begin
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      if (sy == 0) sy = 1;
      if (sx == -64'sd2147483648 && sy == -1) sy = 1;
    end else begin
      sx = longint'({32'b0, x});
      sy = longint'({32'b0, y});
      if (sy == 0) sy = 1;
    end
    return W'(sx / sy);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; exp_done = 1'b0; exp_q = '0;
    end else begin
      bit acc;
      acc = (m_cnt == 0) && start;
      exp_done = 1'b0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin exp_done = 1'b1; exp_q = m_res; end
      end
      if (acc) begin m_cnt = W; m_res = ref_q(sgn, a, b); end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 busy", {31'b0, busy}, {31'b0, (m_cnt > 0)});
      chk("R6 done", {31'b0, done}, {31'b0, exp_done});
      chk({cur_tag, " quotient"}, q, exp_q);
    end
  end

  task automatic issue(bit s, logic [W-1:0] x, logic [W-1:0] y);
    while (busy) @(negedge clk);
    sgn = s; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run(string tag, bit s, logic [W-1:0] x, logic [W-1:0] y);
    cur_tag = tag;
    issue(s, x, y);
    wait_done();
    chk(tag, q, ref_q(s, x, y));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 busy", {31'b0, busy}, '0);
    chk("R9 done", {31'b0, done}, '0);
    chk("R9 quotient", q, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R2", 1'b0, 32'd100, 32'd7);
    chk("R2 value", q, 32'd14);
    run("R1", 1'b1, -32'sd100, 32'd7);
    chk("R1 toward zero", q, -32'sd14);
    run("R1", 1'b1, 32'd100, -32'sd7);
    run("R1", 1'b1, -32'sd100, -32'sd7);
    run("R2", 1'b0, 32'hFFFF_FFFF, 32'd2);
    chk("R2 large", q, 32'h7FFF_FFFF);

    run("R3", 1'b0, 32'hDEAD_BEEF, 32'd0);
    chk("R3 unsigned", q, 32'hDEAD_BEEF);
    run("R3", 1'b1, 32'hDEAD_BEEF, 32'd0);
    chk("R3 signed", q, 32'hDEAD_BEEF);
    run("R4", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
    chk("R4 overflow", q, 32'h8000_0000);
    run("R2", 1'b0, 32'h8000_0000, 32'hFFFF_FFFF);
    chk("R2 unsigned min/ones", q, 32'd0);

    for (int i = 0; i < 2; i++) begin
      run("R1", 1'(i), 32'd0, 32'd13);
      run("R1", 1'(i), 32'd0, 32'hFFFF_FFFF);
      run("R1", 1'(i), 32'h1234_5678, 32'd1);
      run("R1", 1'(i), 32'h9234_5678, 32'hFFFF_FFFF);
      run("R1", 1'(i), 32'h8000_0000, 32'd1);
    end

    // start during busy is ignored
    cur_tag = "R7";
    issue(1'b0, 32'd1000, 32'd10);
    repeat (5) @(negedge clk);
    sgn = 1'b1; a = 32'd77; b = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R7 ignored start", q, 32'd100);
    @(negedge clk);
    chk("R7 still idle", {31'b0, busy}, '0);

    // back to back: start in the done cycle
    cur_tag = "R10";
    issue(1'b0, 32'd500, 32'd5);
    wait_done();
    sgn = 1'b1; a = -32'sd900; b = 32'd30; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 accepted", {31'b0, busy}, 32'd1);
    chk("R8 held", q, 32'd100);
    wait_done();
    chk("R10 second", q, -32'sd30);

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] x, y;
      x = $urandom;
      y = (i % 3 == 0) ? ($urandom & 32'hFF) : $urandom;
      run((i % 2) ? "R1" : "R2", 1'(i % 2), x, y);
    end

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule